// File: doc/BRIEF.md
# Chip-Select Address Decoder

This block turns a 32-bit system-bus address into one of eight active-low chip selects. Each bank owns a configuration word that holds a base field, a per-bit compare mask and an enable bit. A bank claims an address when every compared address bit in the upper field equals the matching base bit. The masked-out bits are don't-care, so each window is a power of two in size and never smaller than 128 KiB. The result is registered once, so each chip select follows the address-valid input by one clock.

The first two banks behave unlike the rest. Their enable bit has no effect on decoding. A zero configuration word makes such a bank swallow every address. An all-ones word confines the bank to the topmost 128 KiB window, and that is the only way to park it. A boot-swap strap is captured while reset is held. When the strap is set, chip selects 0 and 1 trade places at the outputs until the next reset.

Software reaches the configuration words over a simple 32-bit register port, together with five timing words per bank. The timing words are only stored and read back.

Top module: `csel_decoder`

## Requirements
- R1: Configuration word n sits at register offset 0x100 + 0x10*n. Its bits 31:17 are the base field. Bit k in 15:1 enables comparison of address bit k+16. Bit 0 is the enable. A bank matches when ((addr[31:17] ^ word[31:17]) & word[15:1]) == 0.
- R2: Banks 2 to 7 drive their chip select only when word bit 0 is 1 and the address matches. With bit 0 cleared they never select.
- R3: Banks 0 and 1 ignore bit 0. With a zero word they match every address.
- R4: Writing 0xFFFFFFFF to bank 0 or 1 limits it to addresses 0xFFFE0000 to 0xFFFFFFFF.
- R5: When several banks match, only the lowest-numbered one is selected, so at most one chip select is low.
- R6: cs_n reflects bus_valid and bus_addr from the previous clock edge. It is all ones when bus_valid was low.
- R7: When the boot-swap strap is high during reset, logical bank 0 drives cs_n[1] and logical bank 1 drives cs_n[0] until the next reset.
- R8: After reset, bit 0 of the bank 0 word reads as the inverse of the sampled strap. All other bits read zero.
- R9: A configuration word reads back its last written value, starting with the clock edge that takes the write strobe.
- R10: Timing words sit at 0x200 + 0x10*n + 4*i for i = 0 to 3 and at 0x300 + 0x10*n. Each reads back its last written 32-bit value.
- R11: Timing and configuration words reset to zero, except for the bit named in R8. Reads of any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_swap_strap | input | 1 | Strap captured while reset is held |
| bus_valid | input | 1 | Address on bus_addr is valid |
| bus_addr | input | 32 | System-bus address |
| cs_n | output | 8 | Registered active-low chip selects |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |

## Verification
Priority resolution and the boot-swap remap act in the same decode cycle whenever logical banks 0 and 1 both match the address. The bench provokes this case twice. First, with both words zero and the strap set, every address hits both banks. Second, with both words all ones and the strap set, an address in the top window hits both banks. It then checks that only the physical output of logical bank 0 falls, that is cs_n[1]. A third case, with bank 0 parked and bank 1 still zero, confirms that the catch-all of bank 1 lands on cs_n[0].

// File: rtl/csel_pkg.sv
package csel_pkg;

  // Decoded target of a register-port offset
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_CFG    = 2'd1,
    SEL_TIMING = 2'd2
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e    sel;
    logic [3:0]  bank;
    logic [2:0]  tidx;
  } reg_hit_t;

  // Map a byte offset onto configuration or timing storage.
  // Offset fields: [11:8] page, [7:4] bank, [3:2] word, [1:0] byte.
  function automatic reg_hit_t decode_off(input logic [11:0] off, input int nbanks);
    reg_hit_t h;
    h.sel  = SEL_NONE;
    h.bank = off[7:4];
    h.tidx = 3'd0;
    if (off[1:0] == 2'b00 && int'(off[7:4]) < nbanks) begin
      case (off[11:8])
        4'h1: if (off[3:2] == 2'b00) h.sel = SEL_CFG;
        4'h2: begin
          h.sel  = SEL_TIMING;
          h.tidx = {1'b0, off[3:2]};
        end
        4'h3: if (off[3:2] == 2'b00) begin
          h.sel  = SEL_TIMING;
          h.tidx = 3'd4;
        end
        default: h.sel = SEL_NONE;
      endcase
    end
    return h;
  endfunction

endpackage

// File: rtl/csel_reset_ctl.sv
// Reset synchronizer plus boot-strap capture.
module csel_reset_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_strap,
  output logic rst_sync_n,
  output logic swap_q
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

  // Strap follows the pin while reset is held, frozen afterwards
  always_ff @(posedge clk) begin
    if (!rst_sync_n) swap_q <= boot_strap;
  end

endmodule

// File: rtl/csel_regfile.sv
module csel_regfile
  import csel_pkg::*;
#(
  parameter int NUM_BANKS    = 8,
  parameter int DATA_W       = 32,
  parameter int REG_AW       = 12,
  parameter int TIM_PER_BANK = 5,
  parameter int ADDR_W       = 32,
  parameter int GRAN_LSB     = 17
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 boot_strap,
  input  logic                 reg_wr,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic [ADDR_W-1:GRAN_LSB]        base_fld [NUM_BANKS],
  output logic [ADDR_W-GRAN_LSB:1]        cmp_fld  [NUM_BANKS],
  output logic [NUM_BANKS-1:0]            en_fld
);

  localparam int BANK_W = $clog2(NUM_BANKS);

  reg_hit_t                 hit;
  logic [NUM_BANKS-1:0]     cfg_we;
  logic [TIM_PER_BANK-1:0]  tim_we [NUM_BANKS];
  logic [DATA_W-1:0]        cfg_q  [NUM_BANKS];
  logic [DATA_W-1:0]        tim_q  [NUM_BANKS][TIM_PER_BANK];

  // Write strobes
  always_comb begin
    hit = decode_off(reg_addr, NUM_BANKS);
    for (int b = 0; b < NUM_BANKS; b++) begin
      cfg_we[b] = reg_wr && (hit.sel == SEL_CFG) && (hit.bank == 4'(b));
      for (int t = 0; t < TIM_PER_BANK; t++) begin
        tim_we[b][t] = reg_wr && (hit.sel == SEL_TIMING) &&
                       (hit.bank == 4'(b)) && (hit.tidx == 3'(t));
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:1] hi_q;
    logic              en_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hi_q <= '0;
      else if (cfg_we[b]) hi_q <= reg_wdata[DATA_W-1:1];
    end

    if (b == 0) begin : g_strap_en
      // Reset value follows the inverted strap, loaded while reset is held
      always_ff @(posedge clk) begin
        if (!rst_n)         en_q <= ~boot_strap;
        else if (cfg_we[b]) en_q <= reg_wdata[0];
      end
    end else begin : g_plain_en
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         en_q <= 1'b0;
        else if (cfg_we[b]) en_q <= reg_wdata[0];
      end
    end

    assign cfg_q[b]    = {hi_q, en_q};
    assign base_fld[b] = hi_q[ADDR_W-1:GRAN_LSB];
    assign cmp_fld[b]  = hi_q[ADDR_W-GRAN_LSB:1];
    assign en_fld[b]   = en_q;

    for (genvar t = 0; t < TIM_PER_BANK; t++) begin : g_tim
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            word_q <= '0;
        else if (tim_we[b][t]) word_q <= reg_wdata;
      end
      assign tim_q[b][t] = word_q;
    end
  end

  // Read mux
  always_comb begin
    reg_rdata = '0;
    case (hit.sel)
      SEL_CFG:    reg_rdata = cfg_q[hit.bank[BANK_W-1:0]];
      SEL_TIMING: reg_rdata = tim_q[hit.bank[BANK_W-1:0]][hit.tidx];
      default:    reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/csel_bank_match.sv
module csel_bank_match #(
  parameter int FIELD_W = 15
) (
  input  logic [FIELD_W-1:0] addr_hi,
  input  logic [FIELD_W-1:0] base,
  input  logic [FIELD_W-1:0] cmp_en,
  input  logic               enable,
  output logic               hit
);

  logic [FIELD_W-1:0] diff;

  always_comb begin
    diff = (addr_hi ^ base) & cmp_en;
    hit  = enable && (diff == '0);
  end

endmodule

// File: rtl/csel_route.sv
// Priority pick, boot-swap remap and output register.
module csel_route #(
  parameter int NUM_BANKS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 swap,
  input  logic [NUM_BANKS-1:0] bank_hit,
  output logic [NUM_BANKS-1:0] cs_n
);

  logic [NUM_BANKS-1:0] pick;
  logic [NUM_BANKS-1:0] phys;
  logic [NUM_BANKS-1:0] cs_n_d;
  logic [NUM_BANKS-1:0] cs_n_q;
  logic                 found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b] && !found) begin
        pick[b] = 1'b1;
        found   = 1'b1;
      end
    end
    phys = pick;
    if (swap) begin
      phys[0] = pick[1];
      phys[1] = pick[0];
    end
    cs_n_d = bus_valid ? ~phys : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_n_q <= '1;
    else        cs_n_q <= cs_n_d;
  end

  assign cs_n = cs_n_q;

endmodule

// File: rtl/csel_decoder.sv
module csel_decoder #(
  parameter int NUM_BANKS      = 8,
  parameter int ADDR_W         = 32,
  parameter int DATA_W         = 32,
  parameter int REG_AW         = 12,
  parameter int GRAN_LSB       = 17,
  parameter int CATCHALL_BANKS = 2,
  parameter int TIM_PER_BANK   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 boot_swap_strap,
  input  logic                 bus_valid,
  input  logic [ADDR_W-1:0]    bus_addr,
  output logic [NUM_BANKS-1:0] cs_n,
  input  logic                 reg_wr,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata
);

  localparam int FIELD_W = ADDR_W - GRAN_LSB;

  logic                          rst_sync_n;
  logic                          swap_q;
  logic [ADDR_W-1:GRAN_LSB]      base_fld [NUM_BANKS];
  logic [FIELD_W:1]              cmp_fld  [NUM_BANKS];
  logic [NUM_BANKS-1:0]          en_fld;
  logic [NUM_BANKS-1:0]          bank_hit;
  logic                          unused_addr_lo;

  assign unused_addr_lo = ^bus_addr[GRAN_LSB-1:0];

  csel_reset_ctl u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .boot_strap (boot_swap_strap),
    .rst_sync_n (rst_sync_n),
    .swap_q     (swap_q)
  );

  csel_regfile #(
    .NUM_BANKS    (NUM_BANKS),
    .DATA_W       (DATA_W),
    .REG_AW       (REG_AW),
    .TIM_PER_BANK (TIM_PER_BANK),
    .ADDR_W       (ADDR_W),
    .GRAN_LSB     (GRAN_LSB)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .boot_strap (boot_swap_strap),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .base_fld   (base_fld),
    .cmp_fld    (cmp_fld),
    .en_fld     (en_fld)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_match
    logic en_eff;
    if (b < CATCHALL_BANKS) begin : g_forced
      assign en_eff = 1'b1;
    end else begin : g_gated
      assign en_eff = en_fld[b];
    end
    csel_bank_match #(.FIELD_W(FIELD_W)) u_match (
      .addr_hi (bus_addr[ADDR_W-1:GRAN_LSB]),
      .base    (base_fld[b]),
      .cmp_en  (cmp_fld[b]),
      .enable  (en_eff),
      .hit     (bank_hit[b])
    );
  end

  csel_route #(.NUM_BANKS(NUM_BANKS)) u_route (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_valid (bus_valid),
    .swap      (swap_q),
    .bank_hit  (bank_hit),
    .cs_n      (cs_n)
  );

endmodule

// File: rtl/csel_decoder_chk.sv
module csel_decoder_chk #(
  parameter int NUM_BANKS = 8,
  parameter int DATA_W    = 32,
  parameter int REG_AW    = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_valid,
  input logic [NUM_BANKS-1:0] cs_n,
  input logic                 reg_wr,
  input logic [REG_AW-1:0]    reg_addr,
  input logic [DATA_W-1:0]    reg_wdata,
  input logic [DATA_W-1:0]    reg_rdata
);

  // R5
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R6
  idle_when_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> (cs_n == '1));

  // R6
  select_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != '1) |-> $past(bus_valid));

  // R10
  timing_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_wr && reg_addr == 12'h200) && reg_addr == 12'h200)
      |-> reg_rdata == $past(reg_wdata));

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 12'h0FC || reg_addr == 12'h104) |-> reg_rdata == '0);

endmodule

bind csel_decoder csel_decoder_chk #(
  .NUM_BANKS (NUM_BANKS),
  .DATA_W    (DATA_W),
  .REG_AW    (REG_AW)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_valid (bus_valid),
  .cs_n      (cs_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata)
);

// File: tb/csel_decoder_tb_top.sv
module csel_decoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  // Address / expected cs_n after the base configuration
  localparam logic [31:0] TV_ADDR [NV] = '{
    32'h4000_0010, 32'h4001_FFFF, 32'h4002_0000, 32'h1000_0000,
    32'h10FF_FFFC, 32'h1100_0000, 32'h1040_0004, 32'h2000_0000,
    32'h8000_0000, 32'hFFFE_0000, 32'hFFFD_FFFF, 32'h0000_0000};
  localparam logic [7:0] TV_CS [NV] = '{
    8'hFB, 8'hFB, 8'hFF, 8'hF7,
    8'hF7, 8'hFF, 8'hF7, 8'hFF,
    8'h7F, 8'hFE, 8'h7F, 8'hFF};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        boot_swap_strap;
  logic        bus_valid;
  logic [31:0] bus_addr;
  logic [7:0]  cs_n;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csel_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .boot_swap_strap(boot_swap_strap),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .cs_n(cs_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; boot_swap_strap = strap;
    bus_valid = 1'b0; bus_addr = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic probe(input string req, input logic [31:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a;
    @(negedge clk);
    check(req, {24'h0, cs_n}, {24'h0, exp});
  endtask

  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    do_reset(1'b0);
    // Reset state
    check("R6 reset idle", {24'h0, cs_n}, 32'hFF);
    rd_check("R8 bank0 enable = ~strap", 12'h100, 32'h0000_0001);
    rd_check("R11 bank2 cfg reset", 12'h120, 32'h0);
    rd_check("R11 timing reset", 12'h200, 32'h0);
    rd_check("R11 unmapped 0x104", 12'h104, 32'h0);

    // R3: zero words on banks 0/1 catch everything, even inside bank 2
    wr(12'h120, 32'h4000_FFFF);
    probe("R3 catch-all bank0", 32'h4000_0010, 8'hFE);
    probe("R3 catch-all any addr", 32'h1234_5678, 8'hFE);

    // Base configuration
    wr(12'h100, 32'hFFFF_FFFF);
    wr(12'h110, 32'hFFFF_FFFF);
    wr(12'h130, 32'h1000_FF01);
    wr(12'h140, 32'h2000_FFFE);
    wr(12'h150, 32'h1040_FFFF);
    wr(12'h170, 32'h8000_8001);
    rd_check("R9 cfg readback", 12'h130, 32'h1000_FF01);

    // R1 R2 R4 R5 table
    for (int i = 0; i < NV; i++) begin
      probe($sformatf("R1/R2/R4/R5 vector %0d", i), TV_ADDR[i], TV_CS[i]);
    end

    // R2: enabling bank 4 opens its window
    wr(12'h140, 32'h2000_FFFF);
    probe("R2 bank4 enabled", 32'h2000_0000, 8'hEF);

    // R3: clearing bank 0 enable does not disable it
    wr(12'h100, 32'hFFFF_FFFE);
    rd_check("R9 bank0 readback", 12'h100, 32'hFFFF_FFFE);
    probe("R3 enable ignored bank0", 32'hFFFE_0000, 8'hFE);

    // R6: one-cycle latency and idle on invalid
    @(negedge clk);
    bus_valid = 1'b0;
    @(negedge clk);
    check("R6 idle when invalid", {24'h0, cs_n}, 32'hFF);
    bus_valid = 1'b1; bus_addr = 32'h1000_0000;
    #1;
    check("R6 not yet selected", {24'h0, cs_n}, 32'hFF);
    @(negedge clk);
    check("R6 selected after one edge", {24'h0, cs_n}, 32'hF7);

    // R10 timing words
    wr(12'h238, 32'hA5A5_0003);
    wr(12'h370, 32'h1234_5677);
    wr(12'h200, 32'h0BAD_F00D);
    rd_check("R10 timing word bank3 i2", 12'h238, 32'hA5A5_0003);
    rd_check("R10 timing word bank7 upper", 12'h370, 32'h1234_5677);
    rd_check("R10 timing word bank0 i0", 12'h200, 32'h0BAD_F00D);
    rd_check("R11 unmapped beyond banks", 12'h380, 32'h0);
    rd_check("R11 unmapped misaligned", 12'h202, 32'h0);

    // R7: swapped session
    do_reset(1'b1);
    rd_check("R8 bank0 enable with strap", 12'h100, 32'h0);
    probe("R7 swap catch-all to cs1", 32'h4000_0000, 8'hFD);
    wr(12'h100, 32'hFFFF_FFFF);
    probe("R7 bank1 catch-all to cs0", 32'h4000_0000, 8'hFE);
    wr(12'h110, 32'hFFFF_FFFF);
    wr(12'h120, 32'h4000_FFFF);
    probe("R7 bank2 unaffected", 32'h4000_0000, 8'hFB);
    probe("R7 top window bank0 on cs1", 32'hFFFE_0000, 8'hFD);

    finish_run();
  end

endmodule